// File: doc/BRIEF.md
# Hardware Call Stack Engine

This block keeps a downward-growing call stack in a small byte-addressed memory that it owns. It holds a 32-bit stack pointer and a 32-bit base pointer. On a start strobe it runs one stack operation: push, pop, call, return, frame entry, frame exit, pointer adjust, or a read at an offset from the base pointer. Each word is 32 bits wide and is stored least significant byte first.

Every operation takes the same number of cycles. The cycle after the strobe, `busy_o` is high. The cycle after that, `done_o` pulses and the new pointers, the data result and the branch target are all visible at the outputs. A strobe that arrives while the unit is busy is dropped. A sequencer can use the unit to run a whole subroutine linkage. It pushes the arguments last-first and calls. It enters a frame and reads the arguments at base+8 and base+12. It leaves the frame, returns, and then adjusts the pointer by +8 to drop the arguments.

Top module: `call_stack_engine`

## Requirements
- R1: After reset, `sp_o` equals parameter SP_INIT, `bp_o`, `result_o` and `target_o` are zero, and `busy_o` and `done_o` are low.
- R2: A strobe taken in an idle cycle makes `busy_o` high in the next cycle. In the cycle after that, `done_o` is high for exactly one cycle, and all outputs already show the operation's effect. A strobe while `busy_o` is high is ignored.
- R3: Opcode 1 (push) lowers `sp_o` by 4 and then writes `operand_i` at the new pointer. Byte k of the word, bits [8k+7:8k], goes to address sp+k (least significant byte lowest).
- R4: Opcode 2 (pop) puts the word at the pointer on `result_o` and raises `sp_o` by 4.
- R5: Opcode 3 (call) pushes `operand_i` (the return address) as in R3 and puts `target_i` on `target_o`.
- R6: Opcode 4 (return) puts the word at the pointer on `target_o` and raises `sp_o` by 4.
- R7: Opcode 5 (frame entry) pushes the current base pointer as in R3, then sets the base pointer to the new stack pointer.
- R8: Opcode 6 (frame exit) loads the base pointer from the word at the stack pointer and raises `sp_o` by 4.
- R9: Opcode 7 (adjust) adds `operand_i` (two's complement) to the stack pointer and leaves memory contents unchanged.
- R10: Opcode 8 (frame read) puts the word at base pointer plus `operand_i` on `result_o`. The offset may be unaligned, and the word is assembled per R3. Both pointers stay unchanged.
- R11: Only the low log2(MEM_BYTES) address bits select memory bytes, so accesses wrap around the memory. The pointers themselves keep all 32 bits.
- R12: Any other opcode (0, 9 to 15) changes no pointer, output value or memory, but still completes with a `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Operation strobe |
| op_i | input | 4 | Opcode |
| operand_i | input | 32 | Push value, return address, adjust amount or frame offset |
| target_i | input | 32 | Call destination |
| result_o | output | 32 | Last popped or frame-read word |
| target_o | output | 32 | Last call destination or return address |
| sp_o | output | 32 | Stack pointer |
| bp_o | output | 32 | Base pointer |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the fixed step sizes of the stack pointer for push, pop, call and return. They also check that a pushed word reads back at the new top, that the base pointer moves only on frame entry or exit, that adjust leaves memory unchanged, that frame reads keep both pointers, and that done and busy keep their one-cycle timing. Some behaviour only the bench scenarios can show. This covers little-endian byte placement seen through unaligned frame reads, wrap-around at the memory edge, and the full call, frame, return and discard linkage with arguments at base+8 and base+12. It also covers a strobe dropped while busy and unknown opcodes that change nothing.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [3:0] {
        SC_NOP   = 4'd0,
        SC_PUSH  = 4'd1,
        SC_POP   = 4'd2,
        SC_CALL  = 4'd3,
        SC_RET   = 4'd4,
        SC_ENTER = 4'd5,
        SC_LEAVE = 4'd6,
        SC_ADJ   = 4'd7,
        SC_LDARG = 4'd8
    } sc_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } sc_state_e;

    localparam int unsigned WORD_BYTES = 4;

endpackage

// File: rtl/sc_word_read.sv
module sc_word_read #(
    parameter int unsigned MEM_BYTES = 64,
    localparam int unsigned AW = $clog2(MEM_BYTES)
) (
    input  logic [MEM_BYTES-1:0][7:0] bytes_i,
    input  logic [AW-1:0]             addr_i,
    output logic [31:0]               word_o
);
    // Little-endian gather, wrapping inside the memory (R3, R11)
    for (genvar k = 0; k < sc_pkg::WORD_BYTES; k++) begin : g_lane
        logic [AW-1:0] idx;
        assign idx = addr_i + AW'(k);
        assign word_o[8*k +: 8] = bytes_i[idx];
    end
endmodule

// File: rtl/sc_word_write.sv
module sc_word_write #(
    parameter int unsigned MEM_BYTES = 64,
    localparam int unsigned AW = $clog2(MEM_BYTES)
) (
    input  logic [MEM_BYTES-1:0][7:0] bytes_i,
    input  logic                      en_i,
    input  logic [AW-1:0]             addr_i,
    input  logic [31:0]               data_i,
    output logic [MEM_BYTES-1:0][7:0] bytes_o
);
    logic [AW-1:0] idx;

    always_comb begin
        bytes_o = bytes_i;
        idx     = addr_i;
        if (en_i) begin
            for (int k = 0; k < sc_pkg::WORD_BYTES; k++) begin
                idx          = addr_i + AW'(k);
                bytes_o[idx] = data_i[8*k +: 8];
            end
        end
    end
endmodule

// File: rtl/call_stack_engine.sv
module call_stack_engine #(
    parameter int unsigned MEM_BYTES = 64,
    parameter logic [31:0] SP_INIT   = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [3:0]  op_i,
    input  logic [31:0] operand_i,
    input  logic [31:0] target_i,
    output logic [31:0] result_o,
    output logic [31:0] target_o,
    output logic [31:0] sp_o,
    output logic [31:0] bp_o,
    output logic        busy_o,
    output logic        done_o
);
    import sc_pkg::*;

    localparam int unsigned AW   = $clog2(MEM_BYTES);
    localparam logic [31:0] STEP = 32'(WORD_BYTES);

    typedef struct packed {
        sc_state_e                st;
        sc_op_e                   op;
        logic [31:0]              opnd;
        logic [31:0]              tgt_in;
        logic [31:0]              sp;
        logic [31:0]              bp;
        logic [31:0]              res;
        logic [31:0]              tgt;
        logic                     done;
        logic [MEM_BYTES-1:0][7:0] mem;
    } sc_regs_t;

    sc_regs_t q, d;

    logic [31:0]               top_word;
    logic [31:0]               frame_word;
    logic [31:0]               sp_dec;
    logic                      wr_en;
    logic [31:0]               wr_data;
    logic [MEM_BYTES-1:0][7:0] mem_wr;

    assign sp_dec = q.sp - STEP;

    sc_word_read #(.MEM_BYTES(MEM_BYTES)) i_rd_top (
        .bytes_i (q.mem),
        .addr_i  (q.sp[AW-1:0]),
        .word_o  (top_word)
    );

    sc_word_read #(.MEM_BYTES(MEM_BYTES)) i_rd_frame (
        .bytes_i (q.mem),
        .addr_i  (q.bp[AW-1:0] + q.opnd[AW-1:0]),
        .word_o  (frame_word)
    );

    sc_word_write #(.MEM_BYTES(MEM_BYTES)) i_wr (
        .bytes_i (q.mem),
        .en_i    (wr_en),
        .addr_i  (sp_dec[AW-1:0]),
        .data_i  (wr_data),
        .bytes_o (mem_wr)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        wr_en   = 1'b0;
        wr_data = q.opnd;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_EXEC;
                    d.op     = sc_op_e'(op_i);
                    d.opnd   = operand_i;
                    d.tgt_in = target_i;
                end
            end
            ST_EXEC: begin
                d.st   = ST_IDLE;
                d.done = 1'b1;
                case (q.op)
                    SC_PUSH: begin
                        wr_en = 1'b1;
                        d.sp  = sp_dec;
                    end
                    SC_POP: begin
                        d.res = top_word;
                        d.sp  = q.sp + STEP;
                    end
                    SC_CALL: begin
                        wr_en = 1'b1;
                        d.sp  = sp_dec;
                        d.tgt = q.tgt_in;
                    end
                    SC_RET: begin
                        d.tgt = top_word;
                        d.sp  = q.sp + STEP;
                    end
                    SC_ENTER: begin
                        wr_en   = 1'b1;
                        wr_data = q.bp;
                        d.sp    = sp_dec;
                        d.bp    = sp_dec;
                    end
                    SC_LEAVE: begin
                        d.bp = top_word;
                        d.sp = q.sp + STEP;
                    end
                    SC_ADJ: begin
                        d.sp = q.sp + q.opnd;
                    end
                    SC_LDARG: begin
                        d.res = frame_word;
                    end
                    default: ;
                endcase
            end
            default: d.st = ST_IDLE;
        endcase
        d.mem = mem_wr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.op   <= SC_NOP;
            q.sp   <= SP_INIT;
        end else begin
            q <= d;
        end
    end

    assign result_o = q.res;
    assign target_o = q.tgt;
    assign sp_o     = q.sp;
    assign bp_o     = q.bp;
    assign busy_o   = (q.st == ST_EXEC);
    assign done_o   = q.done;

    // R2
    exec_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC) |=> (q.done && q.st == ST_IDLE));

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |=> !q.done);

    // R3
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && (q.op == SC_PUSH || q.op == SC_CALL || q.op == SC_ENTER))
        |=> (q.sp == $past(q.sp) - STEP));

    // R3
    push_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && q.op == SC_PUSH) |=> (top_word == $past(q.opnd)));

    // R4
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && (q.op == SC_POP || q.op == SC_RET || q.op == SC_LEAVE))
        |=> (q.sp == $past(q.sp) + STEP));

    // R7
    bp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.st == ST_EXEC && (q.op == SC_ENTER || q.op == SC_LEAVE)) |=> $stable(q.bp));

    // R9
    adj_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && q.op == SC_ADJ) |=> $stable(q.mem));

    // R10
    ldarg_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_EXEC && q.op == SC_LDARG) |=> ($stable(q.sp) && $stable(q.bp)));

endmodule

// File: tb/test_call_stack_engine.sv
module test_call_stack_engine;

    localparam int          MB      = 64;
    localparam logic [31:0] SP_INIT = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  op_i = 4'd0;
    logic [31:0] operand_i = '0;
    logic [31:0] target_i = '0;
    logic [31:0] result_o, target_o, sp_o, bp_o;
    logic        busy_o, done_o;

    always #5 clk = ~clk;

    call_stack_engine #(.MEM_BYTES(MB), .SP_INIT(SP_INIT)) i_call_stack_engine (
        .clk, .rst_n, .start_i, .op_i, .operand_i, .target_i,
        .result_o, .target_o, .sp_o, .bp_o, .busy_o, .done_o
    );

    typedef struct {
        string       req;
        logic [31:0] sp, bp, res, tgt;
    } exp_t;

    exp_t        sb[$];
    int          total = 0;
    int          bad = 0;
    logic [7:0]  m_mem [MB];
    logic [31:0] m_sp, m_bp, m_res, m_tgt;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] m_rd(input logic [31:0] a);
        logic [31:0] w;
        for (int k = 0; k < 4; k++) w[8*k +: 8] = m_mem[(a + 32'(k)) % MB];
        return w;
    endfunction

    task automatic m_wr(input logic [31:0] a, input logic [31:0] w);
        for (int k = 0; k < 4; k++) m_mem[(a + 32'(k)) % MB] = w[8*k +: 8];
    endtask

    // Driver: models the op, queues the expectation, applies the strobe
    task automatic issue(input logic [3:0] op, input logic [31:0] opnd,
                         input logic [31:0] tgt, input bit poke, input string req);
        exp_t e;
        case (op)
            4'd1: begin m_sp -= 4; m_wr(m_sp, opnd); end
            4'd2: begin m_res = m_rd(m_sp); m_sp += 4; end
            4'd3: begin m_sp -= 4; m_wr(m_sp, opnd); m_tgt = tgt; end
            4'd4: begin m_tgt = m_rd(m_sp); m_sp += 4; end
            4'd5: begin m_sp -= 4; m_wr(m_sp, m_bp); m_bp = m_sp; end
            4'd6: begin m_bp = m_rd(m_sp); m_sp += 4; end
            4'd7: m_sp += opnd;
            4'd8: m_res = m_rd(m_bp + opnd);
            default: ;
        endcase
        e.req = req; e.sp = m_sp; e.bp = m_bp; e.res = m_res; e.tgt = m_tgt;
        sb.push_back(e);
        @(negedge clk);
        start_i = 1'b1; op_i = op; operand_i = opnd; target_i = tgt;
        @(negedge clk);
        check(busy_o === 1'b1, "R2", "busy after strobe", 32'(busy_o), 32'd1);
        check(done_o === 1'b0, "R2", "done early", 32'(done_o), 32'd0);
        if (poke) begin
            // R2: this strobe lands while busy and must be dropped
            op_i = 4'd1; operand_i = 32'hDEAD_BEEF;
        end else begin
            start_i = 1'b0;
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Monitor: compares each completion against the scoreboard
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R2", "unexpected done", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(sp_o === e.sp, e.req, "sp", sp_o, e.sp);
                check(bp_o === e.bp, e.req, "bp", bp_o, e.bp);
                check(result_o === e.res, e.req, "result", result_o, e.res);
                check(target_o === e.tgt, e.req, "target", target_o, e.tgt);
            end
        end
    end

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < MB; i++) m_mem[i] = 8'h00;
        m_sp = SP_INIT; m_bp = '0; m_res = '0; m_tgt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(sp_o === SP_INIT, "R1", "sp reset", sp_o, SP_INIT);
        check(bp_o === 32'd0, "R1", "bp reset", bp_o, 32'd0);
        check({result_o, target_o} === 64'd0, "R1", "result/target reset", result_o, 32'd0);
        check(busy_o === 1'b0 && done_o === 1'b0, "R1", "busy/done reset",
              32'({busy_o, done_o}), 32'd0);

        // Subroutine linkage: args pushed last-first, call, frame, return, discard
        issue(4'd1, 32'd4, 0, 0, "R3");              // second argument
        issue(4'd1, 32'd2, 0, 0, "R3");              // first argument
        issue(4'd3, 32'h0000_0ABC, 32'h0000_0400, 0, "R5");
        issue(4'd5, 0, 0, 0, "R7");
        issue(4'd8, 32'd8, 0, 0, "R10");              // first arg at bp+8
        issue(4'd8, 32'd12, 0, 0, "R10");             // second arg at bp+12
        issue(4'd8, 32'd4, 0, 0, "R10");              // return address
        issue(4'd6, 0, 0, 0, "R8");
        issue(4'd4, 0, 0, 0, "R6");
        issue(4'd7, 32'd8, 0, 0, "R9");               // discard two args
        check(sp_o === SP_INIT, "R9", "sp back at start", sp_o, SP_INIT);
        issue(4'd7, 32'hFFFF_FFF8, 0, 0, "R9");       // re-expose old words
        issue(4'd2, 0, 0, 0, "R9");                   // memory kept: pops 2
        issue(4'd2, 0, 0, 0, "R4");

        // Little-endian placement seen through unaligned frame reads
        issue(4'd1, 32'hA1B2_C3D4, 0, 0, "R3");
        issue(4'd1, 32'h5566_7788, 0, 0, "R3");
        issue(4'd5, 0, 0, 0, "R7");
        issue(4'd8, 32'd5, 0, 0, "R3");
        issue(4'd8, 32'd7, 0, 0, "R10");
        issue(4'd6, 0, 0, 0, "R8");

        // Strobe while busy is ignored
        issue(4'd2, 0, 0, 1, "R2");
        issue(4'd2, 0, 0, 0, "R4");

        // Wrap around the memory edge
        issue(4'd7, 32'd2, 0, 0, "R11");              // sp low bits = 2
        issue(4'd1, 32'hCAFE_F00D, 0, 0, "R11");      // bytes 62,63,0,1
        issue(4'd2, 0, 0, 0, "R11");
        issue(4'd7, 32'hFFFF_FFFE, 0, 0, "R11");

        // Unknown opcodes change nothing
        issue(4'd0, 32'h1234, 32'h99, 0, "R12");
        issue(4'd9, 32'h1234, 32'h99, 0, "R12");
        issue(4'd15, 32'h1234, 32'h99, 0, "R12");
        issue(4'd2, 0, 0, 0, "R12");                  // memory untouched

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R2", "missing completions", 32'(sb.size()), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule